// File: doc/BRIEF.md
# Two-Mode Disk Write Bit Encoder

This block turns a stream of requested (clock, data) bit pairs into flux-transition pulses for a floppy disk write channel. It holds its own half-cell timer. While the write enable is high, it asks for one bit pair per bit cell through `bit_take`. It then produces two half-cells in turn, the clock half-cell first and the data half-cell second. A half-cell whose value is 1 shows up as a single-cycle pulse on `flux_pulse`.

There are two modes. In low-density mode the encoder is plain FM: the requested clock and data bits go out unchanged, and a bit cell lasts twice as long as in high-density mode. In high-density mode the encoder is modified-modified FM. A three-bit history delays each data bit by two cells. The clock bit that goes out is rebuilt from the request and from whether the previous cell carried any transition. Each rising edge of the write enable starts a new write and clears that history.

Top module: `wenc_write_encoder`

## Requirements
- R1: While `wr_en` is low, `flux_pulse` and `bit_take` are 0, including during and right after reset.
- R2: `bit_take` is 1 in the first cycle that `wr_en` is high. After that it is 1 once per bit cell, every 2*HD_HALF cycles in high-density mode (`hd_mode`=1) and every 2*LD_HALF cycles (LD_HALF = 2*HD_HALF) in low-density mode. The pair on `req_clk`/`req_data` is sampled in that cycle.
- R3: A bit cell starts in the cycle after its `bit_take`. The clock half-cell comes first and lasts HD_HALF (or LD_HALF) cycles, with `flux_half`=0. The data half-cell follows with `flux_half`=1. A pulse for a half-cell appears in the first cycle of that half-cell.
- R4: In low-density mode, the clock half-cell pulses exactly when the sampled `req_clk` is 1, and the data half-cell pulses exactly when the sampled `req_data` is 1.
- R5: In high-density mode, the data half-cell of cell k carries the `req_data` sampled for cell k-2.
- R6: In high-density mode, the clock half-cell pulses only when the emitted data bit of the same cell is 0 and either `req_clk` is 1 or the previous cell emitted neither a clock nor a data transition. The emitted clock and data bits of one cell are therefore never both 1.
- R7: A rising edge of `wr_en` clears the history. In high-density mode the first two cells after a start emit data 0, and the first cell always emits a clock transition.
- R8: Each pulse lasts exactly one cycle (HD_HALF ≥ 2). A half-cell of value 0 produces no pulse, and no pulse appears outside the first cycle of a half-cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write enable; a rising edge starts a new write |
| hd_mode | input | 1 | 1 = high-density modified-modified FM, 0 = low-density FM |
| req_clk | input | 1 | Requested clock bit for the cell, sampled when `bit_take` is 1 |
| req_data | input | 1 | Requested data bit for the cell, sampled when `bit_take` is 1 |
| bit_take | output | 1 | The current request pair is consumed in this cycle |
| flux_pulse | output | 1 | One-cycle transition request at the start of a half-cell of value 1 |
| flux_half | output | 1 | Current half-cell: 0 = clock half, 1 = data half |

## Verification
The hardest case to reach from the ports is the clock-insertion branch in high-density mode. It needs a cell whose requested clock is 0 and whose predecessor emitted no transition at all. That situation only arises from a particular run of data bits two cells back, combined with the clock requests in between. The stimulus sweeps every combination of four requested clock bits and four requested data bits in both modes. Each combination is a fresh write, so the cleared history after a start is exercised as well. Longer streams then carry the transition flag across many cells.

// File: rtl/wenc_pkg.sv
package wenc_pkg;

  localparam int HIST_W = 3;

  typedef struct packed {
    logic [HIST_W-1:0] hist;
    logic              had_trans;
    logic              out_clk;
    logic              out_data;
  } enc_res_t;

  // High-density rule: data delayed two cells, clock rebuilt from history.
  function automatic enc_res_t mmfm_step(input logic [HIST_W-1:0] hist,
                                         input logic had_trans,
                                         input logic rq_clk,
                                         input logic rq_data);
    enc_res_t r;
    r.hist      = {hist[HIST_W-2:0], rq_data};
    r.out_data  = r.hist[HIST_W-1];
    r.out_clk   = !r.out_data && (rq_clk || !had_trans);
    r.had_trans = r.out_data || r.out_clk;
    return r;
  endfunction

  // Low-density rule: pass-through, history left as is.
  function automatic enc_res_t fm_step(input logic [HIST_W-1:0] hist,
                                       input logic had_trans,
                                       input logic rq_clk,
                                       input logic rq_data);
    enc_res_t r;
    r.hist      = hist;
    r.had_trans = had_trans;
    r.out_clk   = rq_clk;
    r.out_data  = rq_data;
    return r;
  endfunction

endpackage

// File: rtl/wenc_half_timer.sv
module wenc_half_timer #(
  parameter int HD_HALF = 250,
  parameter int LD_HALF = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic hd_mode,
  output logic half_start,
  output logic data_half,
  output logic cell_end
);
  localparam int CNT_W = (LD_HALF > 1) ? $clog2(LD_HALF) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             phase_q;
  logic [CNT_W-1:0] limit_w;
  logic             last_w;

  assign limit_w = hd_mode ? CNT_W'(HD_HALF - 1) : CNT_W'(LD_HALF - 1);
  assign last_w  = (cnt_q == limit_w);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (last_w) begin
      cnt_q   <= '0;
      phase_q <= !phase_q;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign half_start = run && (cnt_q == '0);
  assign data_half  = phase_q;
  assign cell_end   = run && last_w && phase_q;
endmodule

// File: rtl/wenc_cell_encoder.sv
module wenc_cell_encoder
  import wenc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              start,
  input  logic              hd_mode,
  input  logic              rq_clk,
  input  logic              rq_data,
  output logic              enc_clk,
  output logic              enc_data,
  output logic [HIST_W-1:0] hist_out
);
  logic [HIST_W-1:0] hist_q;
  logic              had_q;
  logic [HIST_W-1:0] base_hist;
  logic              base_had;
  enc_res_t          res_w;

  assign base_hist = start ? '0 : hist_q;
  assign base_had  = start ? 1'b0 : had_q;

  always_comb begin
    if (hd_mode) res_w = mmfm_step(base_hist, base_had, rq_clk, rq_data);
    else         res_w = fm_step(base_hist, base_had, rq_clk, rq_data);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q   <= '0;
      had_q    <= 1'b0;
      enc_clk  <= 1'b0;
      enc_data <= 1'b0;
    end else if (take) begin
      hist_q   <= res_w.hist;
      had_q    <= res_w.had_trans;
      enc_clk  <= res_w.out_clk;
      enc_data <= res_w.out_data;
    end
  end

  assign hist_out = hist_q;
endmodule

// File: rtl/wenc_write_encoder.sv
module wenc_write_encoder
  import wenc_pkg::*;
#(
  parameter int HD_HALF = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic hd_mode,
  input  logic req_clk,
  input  logic req_data,
  output logic bit_take,
  output logic flux_pulse,
  output logic flux_half
);
  localparam int LD_HALF = 2 * HD_HALF;

  logic              active_q;
  logic              run_w;
  logic              start_w;
  logic              half_start_w;
  logic              cell_end_w;
  logic              enc_clk_q;
  logic              enc_data_q;
  logic [HIST_W-1:0] hist_w;

  always_ff @(posedge clk) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= wr_en;
  end

  assign run_w   = active_q && wr_en;
  assign start_w = wr_en && !active_q;

  wenc_half_timer #(.HD_HALF(HD_HALF), .LD_HALF(LD_HALF)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run_w),
    .hd_mode    (hd_mode),
    .half_start (half_start_w),
    .data_half  (flux_half),
    .cell_end   (cell_end_w)
  );

  assign bit_take = start_w || cell_end_w;

  wenc_cell_encoder u_enc (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (bit_take),
    .start    (start_w),
    .hd_mode  (hd_mode),
    .rq_clk   (req_clk),
    .rq_data  (req_data),
    .enc_clk  (enc_clk_q),
    .enc_data (enc_data_q),
    .hist_out (hist_w)
  );

  assign flux_pulse = half_start_w && (flux_half ? enc_data_q : enc_clk_q);
endmodule

// File: rtl/wenc_checker.sv
module wenc_checker #(
  parameter int HD_HALF = 250
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       hd_mode,
  input logic       req_clk,
  input logic       req_data,
  input logic       bit_take,
  input logic       flux_pulse,
  input logic       flux_half,
  input logic       run_w,
  input logic       start_w,
  input logic       enc_clk_q,
  input logic       enc_data_q,
  input logic [2:0] hist_w
);
  localparam int LD_HALF = 2 * HD_HALF;
  localparam int GAP_W   = $clog2(4 * LD_HALF + 2);

  logic [GAP_W-1:0] since_q;
  logic             prev_hd_q;
  logic             mode_moved_q;
  logic [GAP_W-1:0] cell_len_w;

  assign cell_len_w = hd_mode ? GAP_W'(2 * HD_HALF) : GAP_W'(2 * LD_HALF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_q      <= '0;
      prev_hd_q    <= 1'b0;
      mode_moved_q <= 1'b1;
    end else begin
      prev_hd_q <= hd_mode;
      if (bit_take) begin
        since_q      <= GAP_W'(1);
        mode_moved_q <= 1'b0;
      end else begin
        if (since_q != '1) since_q <= since_q + 1'b1;
        if (hd_mode != prev_hd_q) mode_moved_q <= 1'b1;
      end
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (!flux_pulse && !bit_take));

  assert_cell_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_take && !start_w && !mode_moved_q && (hd_mode == prev_hd_q)) |-> (since_q == cell_len_w));

  assert_clock_half_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_w) |-> !flux_half);

  assert_take_in_data_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_take && !start_w) |-> flux_half);

  assert_fm_passthrough_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_take && !hd_mode) |=> (enc_clk_q == $past(req_clk) && enc_data_q == $past(req_data)));

  assert_data_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_take && hd_mode && !start_w) |=> (enc_data_q == $past(hist_w[1])));

  assert_no_double_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_take && hd_mode) |=> !(enc_clk_q && enc_data_q));

  assert_start_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_w && hd_mode) |=> (enc_clk_q && !enc_data_q && hist_w[1:0] == {1'b0, $past(req_data)}));

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flux_pulse |=> !flux_pulse);
endmodule

bind wenc_write_encoder wenc_checker #(.HD_HALF(HD_HALF)) u_wenc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .hd_mode    (hd_mode),
  .req_clk    (req_clk),
  .req_data   (req_data),
  .bit_take   (bit_take),
  .flux_pulse (flux_pulse),
  .flux_half  (flux_half),
  .run_w      (run_w),
  .start_w    (start_w),
  .enc_clk_q  (enc_clk_q),
  .enc_data_q (enc_data_q),
  .hist_w     (hist_w)
);

// File: tb/wenc_write_encoder_bench.sv
`timescale 1ns/1ps
module wenc_write_encoder_bench;
  localparam int HDH = 3;
  localparam int LDH = 2 * HDH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic hd_mode = 1'b0;
  logic req_clk = 1'b0;
  logic req_data = 1'b0;
  logic bit_take, flux_pulse, flux_half;

  int total = 0;
  int bad = 0;

  always #2 clk = !clk;

  wenc_write_encoder #(.HD_HALF(HDH)) u_wenc_write_encoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .hd_mode(hd_mode),
    .req_clk(req_clk), .req_data(req_data),
    .bit_take(bit_take), .flux_pulse(flux_pulse), .flux_half(flux_half)
  );

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic run_stream(input bit hd, input int n, input logic [15:0] cb, input logic [15:0] db);
    logic [15:0] ec, ed;
    logic prev;
    int h, cl;
    prev = 1'b0;
    for (int k = 0; k < n; k++) begin
      if (hd) begin
        ed[k] = (k >= 2) ? db[k-2] : 1'b0;
        ec[k] = !ed[k] && (cb[k] || !prev);
        prev  = ec[k] || ed[k];
      end else begin
        ec[k] = cb[k];
        ed[k] = db[k];
      end
    end
    h  = hd ? HDH : LDH;
    cl = 2 * h;
    for (int c = 0; c < n * cl; c++) begin
      int k, ph;
      @(negedge clk);
      wr_en = 1'b1; hd_mode = hd;
      k = c / cl; ph = c % cl;
      req_clk = cb[k]; req_data = db[k];
      #1;
      chk(bit_take, (ph == 0), "R2", "bit_take");
      if (ph == 1) begin
        chk(flux_half, 1'b0, "R3", "clock half select");
        chk(flux_pulse, ec[k], !hd ? "R4" : (k == 0 ? "R7" : "R6"), "clock half-cell");
      end else if (ph == h + 1) begin
        chk(flux_half, 1'b1, "R3", "data half select");
        chk(flux_pulse, ed[k], !hd ? "R4" : (k < 2 ? "R7" : "R5"), "data half-cell");
      end else begin
        chk(flux_pulse, 1'b0, "R8", "no pulse mid half-cell");
      end
    end
    @(negedge clk);
    wr_en = 1'b0; req_clk = 1'b1; req_data = 1'b1;
    #1;
    chk(flux_pulse, 1'b0, "R1", "pulse while disabled");
    chk(bit_take, 1'b0, "R1", "take while disabled");
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) begin
      @(negedge clk); #1;
      chk(flux_pulse, 1'b0, "R1", "pulse in reset");
      chk(bit_take, 1'b0, "R1", "take in reset");
    end
    @(negedge clk); rst_n = 1'b1;
    repeat (2) begin
      @(negedge clk); #1;
      chk(flux_pulse, 1'b0, "R1", "pulse after reset");
      chk(bit_take, 1'b0, "R1", "take after reset");
    end
    // R5 R6 R7 exhaustive sweep over four-cell patterns in both modes
    for (int p = 0; p < 256; p++) begin
      for (int m = 0; m < 2; m++) begin
        logic [7:0] pv;
        pv = p[7:0];
        run_stream(m[0], 4, {12'h000, pv[3:0]}, {12'h000, pv[7:4]});
      end
    end
    // R4 R6 long streams carrying the transition flag across many cells
    run_stream(1'b1, 16, 16'h0000, 16'h0000);
    run_stream(1'b1, 16, 16'h0000, 16'hA5C3);
    run_stream(1'b1, 16, 16'h3C0F, 16'h1111);
    run_stream(1'b1, 16, 16'hFFFF, 16'hFFFF);
    run_stream(1'b0, 16, 16'hFFFF, 16'h5A96);
    run_stream(1'b0, 16, 16'h0F0F, 16'h0000);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule